// File: doc/BRIEF.md
# Receive Port Selection Controller

This block arbitrates access to a receive data path that several devices share on one bus, in the manner of a cell-level PHY/ATM receive interface. On each rising edge of the receive clock it samples an active-low chip enable, an active-low port reset and an active-low read enable. From these samples it keeps two pieces of state: an address-match condition and a selected state. It drives output enables for the shared data bus and for the empty/full flag pair. It also issues a read strobe to the attached receive FIFO or output register.

A mode input chooses between FIFO-buffered operation and FIFO-bypassed operation. In FIFO mode, the flags mirror the FIFO's status, and a read is only requested when the FIFO holds data. In bypass mode, the output register delivers a new character on every clock while the port is selected. The flags then report not-empty, unless a sync character sits in the output register while a non-zero discard policy is in force. Tri-state pins are modelled as separate enables, and a data output is forced to zero whenever its enable is low.

Top module: `rx_port_select`

## Requirements
- R1: When a rising clock edge samples `ce_n` = 0 and `port_rst_n` = 1, `match` is 1 after that edge.
- R2: When a rising edge samples `ce_n` = 1 or `port_rst_n` = 0, `match` is 0 after that edge.
- R3: `selected` becomes 1 only at an edge where `match` was already 1 before the edge, `rd_en_n` is sampled 0, and `rd_en_n` was sampled 1 at the previous edge. A low `rd_en_n` that has stayed low does not select the port.
- R4: Once set, `selected` stays 1 until an edge samples `rd_en_n` = 1, which clears it after that edge. This holds whatever `match` does.
- R5: `flag_oe` equals `match`. While `flag_oe` is 0, `empty_flag` and `full_flag` are 0.
- R6: `data_oe` equals `selected` in both modes.
- R7: In FIFO mode (`bypass_mode` = 0), `rd_strobe` = `selected` AND NOT `fifo_empty`, so an empty FIFO is never read.
- R8: In bypass mode (`bypass_mode` = 1), `rd_strobe` is 1 on every cycle that `selected` is 1.
- R9: In FIFO mode with `flag_oe` = 1, `empty_flag` follows `fifo_empty` and `full_flag` follows `fifo_full`.
- R10: In bypass mode with `flag_oe` = 1, `full_flag` is 0. `empty_flag` is 1 exactly when `sync_held` = 1 and `discard_policy` is non-zero.
- R11: While `rst_n` is 0, `match` and `selected` are 0 and the stored read-enable sample is 1. If `rd_en_n` is low at the first edge after reset, that edge counts as a falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| ce_n | input | 1 | Active-low chip enable (address decode) |
| port_rst_n | input | 1 | Active-low receive port reset |
| rd_en_n | input | 1 | Active-low read enable |
| bypass_mode | input | 1 | 0 = FIFO mode, 1 = bypass mode |
| fifo_empty | input | 1 | FIFO empty status |
| fifo_full | input | 1 | FIFO full status |
| sync_held | input | 1 | Output register holds a sync character (bypass mode) |
| discard_policy | input | POLICY_W | Receiver discard policy; non-zero means active |
| match | output | 1 | Address-match condition |
| selected | output | 1 | Port selected state |
| data_oe | output | 1 | Data-bus output enable |
| flag_oe | output | 1 | Empty/full flag output enable |
| empty_flag | output | 1 | Empty flag value (0 when not enabled) |
| full_flag | output | 1 | Full flag value (0 when not enabled) |
| rd_strobe | output | 1 | Read request to FIFO or output register |

## Verification
The properties assume that every control input is synchronous to the receive clock and stable around its rising edge. They also assume that `rst_n` leaves reset in step with that clock, so each sampled value is the one that was driven during the preceding low phase. The stimulus changes every input only on the falling clock edge and releases reset on a falling edge, which keeps it inside those assumptions. The bench covers matched and unmatched read-enable falls, a read enable held low across a new match, port-reset drops, mode changes mid-run, and a long stretch of random input combinations.

// File: rtl/rx_port_select_pkg.sv
package rx_port_select_pkg;

  typedef enum logic {
    RX_MODE_FIFO   = 1'b0,
    RX_MODE_BYPASS = 1'b1
  } rx_mode_e;

  typedef struct packed {
    logic empty;
    logic full;
  } rx_flags_t;

endpackage

// File: rtl/rx_match_track.sv
module rx_match_track (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic port_rst_n,
  output logic match_o
);

  logic match_d;
  logic match_q;

  // Address match holds while the port is enabled and out of reset
  always_comb begin
    match_d = match_q;
    if (ce_n || !port_rst_n) match_d = 1'b0;
    else                     match_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_q <= 1'b0;
    else        match_q <= match_d;
  end

  assign match_o = match_q;

endmodule

// File: rtl/rx_select_fsm.sv
module rx_select_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic match_i,
  input  logic rd_en_n,
  output logic selected_o
);

  logic rd_prev_q;
  logic sel_d;
  logic sel_q;
  logic rd_fall;

  assign rd_fall = rd_prev_q && !rd_en_n;

  always_comb begin
    sel_d = sel_q;
    if (rd_en_n)                 sel_d = 1'b0;
    else if (match_i && rd_fall) sel_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_prev_q <= 1'b1;
      sel_q     <= 1'b0;
    end else begin
      rd_prev_q <= rd_en_n;
      sel_q     <= sel_d;
    end
  end

  assign selected_o = sel_q;

endmodule

// File: rtl/rx_flag_drive.sv
module rx_flag_drive
  import rx_port_select_pkg::*;
#(
  parameter int POLICY_W = 2
) (
  input  rx_mode_e             mode,
  input  logic                 match_i,
  input  logic                 fifo_empty,
  input  logic                 fifo_full,
  input  logic                 sync_held,
  input  logic [POLICY_W-1:0]  discard_policy,
  output logic                 flag_oe,
  output rx_flags_t            flags_o
);

  logic      policy_active;
  rx_flags_t raw;

  assign policy_active = (discard_policy != '0);

  always_comb begin
    unique case (mode)
      RX_MODE_BYPASS: begin
        raw.empty = sync_held && policy_active;
        raw.full  = 1'b0;
      end
      default: begin
        raw.empty = fifo_empty;
        raw.full  = fifo_full;
      end
    endcase
  end

  assign flag_oe = match_i;
  assign flags_o = match_i ? raw : '0;

endmodule

// File: rtl/rx_port_select.sv
module rx_port_select
  import rx_port_select_pkg::*;
#(
  parameter int POLICY_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ce_n,
  input  logic                port_rst_n,
  input  logic                rd_en_n,
  input  logic                bypass_mode,
  input  logic                fifo_empty,
  input  logic                fifo_full,
  input  logic                sync_held,
  input  logic [POLICY_W-1:0] discard_policy,
  output logic                match,
  output logic                selected,
  output logic                data_oe,
  output logic                flag_oe,
  output logic                empty_flag,
  output logic                full_flag,
  output logic                rd_strobe
);

  rx_mode_e  mode;
  rx_flags_t flags;
  logic      read_ok;

  assign mode = rx_mode_e'(bypass_mode);

  rx_match_track u_match (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_n       (ce_n),
    .port_rst_n (port_rst_n),
    .match_o    (match)
  );

  rx_select_fsm u_select (
    .clk        (clk),
    .rst_n      (rst_n),
    .match_i    (match),
    .rd_en_n    (rd_en_n),
    .selected_o (selected)
  );

  rx_flag_drive #(.POLICY_W(POLICY_W)) u_flags (
    .mode           (mode),
    .match_i        (match),
    .fifo_empty     (fifo_empty),
    .fifo_full      (fifo_full),
    .sync_held      (sync_held),
    .discard_policy (discard_policy),
    .flag_oe        (flag_oe),
    .flags_o        (flags)
  );

  // Bypass output register always has a character; FIFO needs data
  assign read_ok    = (mode == RX_MODE_BYPASS) || !fifo_empty;
  assign rd_strobe  = selected && read_ok;
  assign data_oe    = selected;
  assign empty_flag = flags.empty;
  assign full_flag  = flags.full;

endmodule

// File: rtl/rx_port_select_chk.sv
module rx_port_select_chk (
  input logic clk,
  input logic rst_n,
  input logic ce_n,
  input logic port_rst_n,
  input logic rd_en_n,
  input logic bypass_mode,
  input logic fifo_empty,
  input logic sync_held,
  input logic match,
  input logic selected,
  input logic flag_oe,
  input logic empty_flag,
  input logic full_flag,
  input logic rd_strobe
);

  AST_MATCH_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && port_rst_n) |=> match); // R1

  AST_MATCH_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || !port_rst_n) |=> !match); // R2

  AST_SEL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(selected) |-> ($past(match) && !$past(rd_en_n))); // R3

  AST_SEL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_n |=> !selected); // R4

  AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_oe |-> (!empty_flag && !full_flag)); // R5

  AST_NO_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass_mode && fifo_empty) |-> !rd_strobe); // R7

  AST_BYP_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass_mode && selected) |-> rd_strobe); // R8

  AST_BYP_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass_mode && !sync_held) |-> (!empty_flag && !full_flag)); // R10

endmodule

bind rx_port_select rx_port_select_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ce_n        (ce_n),
  .port_rst_n  (port_rst_n),
  .rd_en_n     (rd_en_n),
  .bypass_mode (bypass_mode),
  .fifo_empty  (fifo_empty),
  .sync_held   (sync_held),
  .match       (match),
  .selected    (selected),
  .flag_oe     (flag_oe),
  .empty_flag  (empty_flag),
  .full_flag   (full_flag),
  .rd_strobe   (rd_strobe)
);

// File: tb/rx_port_select_bench.sv
module rx_port_select_bench;

  localparam int CLK_PERIOD = 10;
  localparam int POLICY_W   = 2;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rst_n;
  logic ce_n, port_rst_n, rd_en_n, bypass_mode;
  logic fifo_empty, fifo_full, sync_held;
  logic [POLICY_W-1:0] discard_policy;
  logic match, selected, data_oe, flag_oe, empty_flag, full_flag, rd_strobe;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    logic match, selected, data_oe, flag_oe, empty_flag, full_flag, rd_strobe;
    string t_match, t_sel, t_strobe, t_flag;
  } exp_t;

  exp_t exp_q[$];

  // Bench's own view of the state, written from the requirements
  logic m_match, m_sel, m_prev;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_port_select #(.POLICY_W(POLICY_W)) u_rx_port_select (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .port_rst_n(port_rst_n),
    .rd_en_n(rd_en_n), .bypass_mode(bypass_mode), .fifo_empty(fifo_empty),
    .fifo_full(fifo_full), .sync_held(sync_held), .discard_policy(discard_policy),
    .match(match), .selected(selected), .data_oe(data_oe), .flag_oe(flag_oe),
    .empty_flag(empty_flag), .full_flag(full_flag), .rd_strobe(rd_strobe)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Driver: apply inputs on the falling edge and queue the expected result
  task automatic step(logic ce, logic prst, logic rd, logic byp,
                      logic fe, logic ff, logic sh, logic [POLICY_W-1:0] pol);
    exp_t e;
    logic n_match, n_sel;
    @(negedge clk);
    ce_n = ce; port_rst_n = prst; rd_en_n = rd; bypass_mode = byp;
    fifo_empty = fe; fifo_full = ff; sync_held = sh; discard_policy = pol;
    n_match = !ce && prst;                                   // R1 / R2
    if (rd)                          n_sel = 1'b0;           // R4
    else if (m_match && m_prev)      n_sel = 1'b1;           // R3
    else                             n_sel = m_sel;
    m_prev = rd; m_match = n_match; m_sel = n_sel;
    e.match    = m_match;
    e.selected = m_sel;
    e.data_oe  = m_sel;                                      // R6
    e.flag_oe  = m_match;                                    // R5
    if (!m_match) begin
      e.empty_flag = 1'b0; e.full_flag = 1'b0;
    end else if (byp) begin                                  // R10
      e.empty_flag = sh && (pol != 0); e.full_flag = 1'b0;
    end else begin                                           // R9
      e.empty_flag = fe; e.full_flag = ff;
    end
    e.rd_strobe = m_sel && (byp || !fe);                     // R7 / R8
    e.t_match  = m_match ? "R1" : "R2";
    e.t_sel    = rd ? "R4" : "R3";
    e.t_strobe = byp ? "R8" : "R7";
    e.t_flag   = !m_match ? "R5" : (byp ? "R10" : "R9");
    exp_q.push_back(e);
  endtask

  // Monitor: compare a quarter period after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk(e.t_match,  "match",      match,      e.match);
        chk(e.t_sel,    "selected",   selected,   e.selected);
        chk("R6",       "data_oe",    data_oe,    e.data_oe);
        chk("R5",       "flag_oe",    flag_oe,    e.flag_oe);
        chk(e.t_flag,   "empty_flag", empty_flag, e.empty_flag);
        chk(e.t_flag,   "full_flag",  full_flag,  e.full_flag);
        chk(e.t_strobe, "rd_strobe",  rd_strobe,  e.rd_strobe);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    ce_n = 1'b0; port_rst_n = 1'b1; rd_en_n = 1'b0; bypass_mode = 1'b0;
    fifo_empty = 1'b0; fifo_full = 1'b1; sync_held = 1'b0; discard_policy = '0;
    m_match = 1'b0; m_sel = 1'b0; m_prev = 1'b1;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    // R11: reset state with enable and read active on the inputs
    chk("R11", "match",     match,     1'b0);
    chk("R11", "selected",  selected,  1'b0);
    chk("R11", "flag_oe",   flag_oe,   1'b0);
    chk("R11", "data_oe",   data_oe,   1'b0);
    chk("R11", "rd_strobe", rd_strobe, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    // R11: rd low at first edge counts as a fall, but no match yet
    step(0,1,0, 0, 0,0,0,0);
    step(0,1,0, 0, 0,0,0,0);   // R3: held low across new match, no select
    step(0,1,1, 0, 0,1,0,0);   // R9 flags mirror fifo
    step(0,1,0, 0, 0,0,0,0);   // R3 select, R7 strobe
    step(0,1,0, 0, 1,0,0,0);   // R7 empty fifo: no strobe
    step(1,1,0, 0, 0,0,0,0);   // R4 stays selected without match
    step(1,1,0, 0, 0,0,0,0);
    step(1,1,1, 0, 0,0,0,0);   // R4 deselect
    step(1,1,0, 0, 0,0,0,0);   // R3 fall without match: no select
    step(0,0,1, 0, 0,0,0,0);   // R2 port reset blocks match
    step(0,0,0, 0, 0,0,0,0);
    step(0,1,1, 1, 0,0,1,0);   // R10 sync held, policy 0 -> not empty
    step(0,1,0, 1, 1,1,1,2'd1);// R8 select in bypass; R10 empty
    step(0,1,0, 1, 1,0,0,2'd3);
    step(0,1,0, 1, 0,0,1,2'd2);
    step(0,1,1, 1, 0,0,0,0);
    step(0,1,1, 0, 1,1,0,0);

    for (int i = 0; i < 400; i++) begin
      step(logic'($urandom_range(0,3) == 0), logic'($urandom_range(0,5) != 0),
           logic'($urandom_range(0,1)), logic'($urandom_range(0,1)),
           logic'($urandom_range(0,1)), logic'($urandom_range(0,1)),
           logic'($urandom_range(0,1)), POLICY_W'($urandom_range(0,3)));
    end

    repeat (2) @(posedge clk);
    #(CLK_PERIOD/2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule